// File: doc/BRIEF.md
# USB Speed Mode Policy Controller

This block decides, for each attach of a USB device core to the host, whether the core may run the high-speed chirp handshake or has to come up as full-speed only. It also decides when the D+ pull-up is switched on to signal the attach. The boot memory reader supplies a single pulse once it has finished. With that pulse come a flag that says whether a configuration byte was found and the byte itself. Firmware owns a speed-disable bit that it can write and read back. The host sees an attach only when the cable is present and the external reset pin is released.

A configuration byte whose speed bit is 1 sets a sticky lock. The lock forces the firmware bit to 1, and firmware writes to that bit are ignored. Every attach is then full-speed for as long as the device stays powered. Only power-on reset clears the lock. When no lock is set, a firmware change of the bit takes effect at the next detach followed by reattach. The chirp-enable level is captured when the pull-up turns on, and it holds for the whole connection. A two-bit status word reports the lock flag and the captured chirp-enable level.

Top module: `usb_speed_policy`

## Requirements
- R1: After power-on reset, pullup_en, chirp_en, fw_speed_dis and both status bits read 0.
- R2: When the first boot_done pulse reports no configuration byte (boot_present=0), an attach has chirp_en=1 and fw_speed_dis stays 0.
- R3: When the configuration byte has bit 7 set, fw_speed_dis reads 1 and status[1] (lock) reads 1 from the cycle after boot_done, and every attach has chirp_en=0.
- R4: While locked, a firmware write of 0 to the speed-disable bit is ignored: fw_speed_dis stays 1 and a later reattach still has chirp_en=0.
- R5: When the configuration byte has bit 7 clear, fw_speed_dis reads 0, and a firmware write (fw_wr with fw_wdata) shows on fw_speed_dis one cycle later.
- R6: A firmware change of the bit while attached leaves chirp_en unchanged. After a detach and reattach, chirp_en equals the inverse of fw_speed_dis.
- R7: pullup_en stays 0 while ext_rst_n is low, even with the cable present. It rises on the third rising clock edge after the later of ext_rst_n and cable_in goes high, once boot_done has been seen.
- R8: pullup_en falls three rising edges after cable_in or ext_rst_n goes low, and chirp_en is 0 whenever pullup_en is 0.
- R9: The lock survives external reset and disconnect. Only power-on reset clears it.
- R10: Only the first boot_done pulse after power-on reset is used. Later pulses change neither the lock nor fw_speed_dis.
- R11: status[1] gives the lock flag and status[0] gives chirp_en, the value captured at the current attach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously, released through a synchronizer |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| cable_in | input | 1 | Cable connected level, asynchronous to clk |
| boot_done | input | 1 | One-cycle pulse when the boot memory reader has finished |
| boot_present | input | 1 | A configuration byte was found |
| boot_byte | input | 8 | Configuration byte; bit 7 = 1 disables the chirp |
| fw_wr | input | 1 | Firmware write strobe for the speed-disable bit |
| fw_wdata | input | 1 | Value written; 1 = full-speed only |
| fw_speed_dis | output | 1 | Firmware speed-disable bit read-back |
| pullup_en | output | 1 | D+ pull-up enable |
| chirp_en | output | 1 | Chirp handshake allowed for the current attach |
| status | output | 2 | {lock flag, captured chirp_en} |

## Verification
The boot byte and firmware writes land in their registers on the first rising edge, so fw_speed_dis and status[1] are checked at the falling edge that follows. The cable and external reset levels pass through two synchronizer flops and then the attach state register, so pullup_en and chirp_en move on the third rising edge. The latency test checks at the falling edges after the second and third rising edges and expects 0 and then 1. The other tests drive a level change and wait six cycles before they sample.

// File: rtl/usb_speed_pkg.sv
package usb_speed_pkg;
  typedef enum logic [0:0] {
    LINK_DETACHED = 1'b0,
    LINK_ATTACHED = 1'b1
  } link_state_e;

  localparam int unsigned CFG_SPEED_BIT = 7;
endpackage

// File: rtl/usb_sp_sync.sv
module usb_sp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= '0;
    else        pipe_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= '0;
      else        pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/usb_sp_cfg.sv
module usb_sp_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_done,
  input  logic boot_present,
  input  logic boot_bit,
  input  logic fw_wr,
  input  logic fw_wdata,
  output logic locked,
  output logic fw_bit,
  output logic boot_seen
);
  logic locked_d, fw_bit_d, seen_d;
  logic take_boot;

  // Only the first completion pulse after power-on counts.
  assign take_boot = boot_done && !boot_seen;

  always_comb begin
    locked_d = locked;
    fw_bit_d = fw_bit;
    seen_d   = boot_seen;
    if (take_boot) begin
      seen_d = 1'b1;
      if (boot_present) begin
        locked_d = boot_bit;
        fw_bit_d = boot_bit;
      end
    end else if (fw_wr && !locked) begin
      fw_bit_d = fw_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      fw_bit    <= 1'b0;
      boot_seen <= 1'b0;
    end else begin
      locked    <= locked_d;
      fw_bit    <= fw_bit_d;
      boot_seen <= seen_d;
    end
  end
endmodule

// File: rtl/usb_sp_attach.sv
module usb_sp_attach
  import usb_speed_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ok,
  input  logic cable_ok,
  input  logic boot_seen,
  input  logic chirp_req,
  output logic pullup_en,
  output logic chirp_en
);
  link_state_e state_q, state_d;
  logic        chirp_q, chirp_d;
  logic        ready;

  assign ready = ext_ok && cable_ok && boot_seen;

  always_comb begin
    state_d = state_q;
    chirp_d = chirp_q;
    unique case (state_q)
      LINK_DETACHED: begin
        if (ready) begin
          state_d = LINK_ATTACHED;
          chirp_d = chirp_req;
        end
      end
      LINK_ATTACHED: begin
        if (!ready) begin
          state_d = LINK_DETACHED;
          chirp_d = 1'b0;
        end
      end
      default: begin
        state_d = LINK_DETACHED;
        chirp_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LINK_DETACHED;
      chirp_q <= 1'b0;
    end else begin
      state_q <= state_d;
      chirp_q <= chirp_d;
    end
  end

  assign pullup_en = (state_q == LINK_ATTACHED);
  assign chirp_en  = chirp_q;
endmodule

// File: rtl/usb_speed_policy.sv
module usb_speed_policy
  import usb_speed_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_WIDTH   = 8
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 ext_rst_n,
  input  logic                 cable_in,
  input  logic                 boot_done,
  input  logic                 boot_present,
  input  logic [CFG_WIDTH-1:0] boot_byte,
  input  logic                 fw_wr,
  input  logic                 fw_wdata,
  output logic                 fw_speed_dis,
  output logic                 pullup_en,
  output logic                 chirp_en,
  output logic [1:0]           status
);
  localparam int unsigned LVL_W = 2;

  logic             rst_n_int;
  logic [LVL_W-1:0] lvl_sync;
  logic             locked, fw_bit, boot_seen;

  usb_sp_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_por_sync (
    .clk  (clk),
    .rst_n(por_n),
    .d_in (1'b1),
    .q_out(rst_n_int)
  );

  usb_sp_sync #(.STAGES(SYNC_STAGES), .WIDTH(LVL_W)) u_lvl_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_in ({ext_rst_n, cable_in}),
    .q_out(lvl_sync)
  );

  usb_sp_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .boot_done   (boot_done),
    .boot_present(boot_present),
    .boot_bit    (boot_byte[CFG_SPEED_BIT]),
    .fw_wr       (fw_wr),
    .fw_wdata    (fw_wdata),
    .locked      (locked),
    .fw_bit      (fw_bit),
    .boot_seen   (boot_seen)
  );

  usb_sp_attach u_attach (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ext_ok   (lvl_sync[1]),
    .cable_ok (lvl_sync[0]),
    .boot_seen(boot_seen),
    .chirp_req(!(locked || fw_bit)),
    .pullup_en(pullup_en),
    .chirp_en (chirp_en)
  );

  assign fw_speed_dis = fw_bit;
  assign status       = {locked, chirp_en};
endmodule

// File: rtl/usb_speed_policy_chk.sv
module usb_speed_policy_chk (
  input logic       clk,
  input logic       por_n,
  input logic       fw_speed_dis,
  input logic       pullup_en,
  input logic       chirp_en,
  input logic [1:0] status
);
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    status[1] |=> status[1]);

  p_lock_no_chirp_r3: assert property (@(posedge clk) disable iff (!por_n)
    status[1] |-> !chirp_en);

  p_lock_fw_one_r4: assert property (@(posedge clk) disable iff (!por_n)
    status[1] |-> fw_speed_dis);

  p_chirp_held_r6: assert property (@(posedge clk) disable iff (!por_n)
    (pullup_en && $past(pullup_en)) |-> $stable(chirp_en));

  p_chirp_needs_pullup_r8: assert property (@(posedge clk) disable iff (!por_n)
    !pullup_en |-> !chirp_en);
endmodule

bind usb_speed_policy usb_speed_policy_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .fw_speed_dis(fw_speed_dis),
  .pullup_en   (pullup_en),
  .chirp_en    (chirp_en),
  .status      (status)
);

// File: tb/test_usb_speed_policy.sv
module test_usb_speed_policy;
  logic       clk = 1'b0;
  logic       por_n, ext_rst_n, cable_in, boot_done, boot_present, fw_wr, fw_wdata;
  logic [7:0] boot_byte;
  logic       fw_speed_dis, pullup_en, chirp_en;
  logic [1:0] status;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  usb_speed_policy i_usb_speed_policy (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .cable_in(cable_in),
    .boot_done(boot_done), .boot_present(boot_present), .boot_byte(boot_byte),
    .fw_wr(fw_wr), .fw_wdata(fw_wdata), .fw_speed_dis(fw_speed_dis),
    .pullup_en(pullup_en), .chirp_en(chirp_en), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0; ext_rst_n = 1'b0; cable_in = 1'b0;
    boot_done = 1'b0; boot_present = 1'b0; boot_byte = 8'h00;
    fw_wr = 1'b0; fw_wdata = 1'b0;
    cyc(3);
    por_n = 1'b1;
    cyc(4);
  endtask

  task automatic boot(input logic present, input logic [7:0] b);
    boot_done = 1'b1; boot_present = present; boot_byte = b;
    cyc(1);
    boot_done = 1'b0;
    cyc(1);
  endtask

  task automatic fw_write(input logic v);
    fw_wr = 1'b1; fw_wdata = v;
    cyc(1);
    fw_wr = 1'b0;
  endtask

  task automatic attach();
    ext_rst_n = 1'b1; cable_in = 1'b1;
    cyc(6);
  endtask

  task automatic detach();
    cable_in = 1'b0;
    cyc(6);
  endtask

  task automatic t_reset();
    do_por();
    chk("R1 pullup", pullup_en, 0);
    chk("R1 chirp", chirp_en, 0);
    chk("R1 fw bit", fw_speed_dis, 0);
    chk("R1 status", status, 0);
  endtask

  task automatic t_no_cfg();
    do_por();
    boot(1'b0, 8'hFF);
    chk("R2 fw bit", fw_speed_dis, 0);
    cable_in = 1'b1;
    cyc(6);
    chk("R7 held in reset", pullup_en, 0);
    ext_rst_n = 1'b1;
    cyc(2);
    chk("R7 not yet", pullup_en, 0);
    cyc(1);
    chk("R7 pullup on 3rd edge", pullup_en, 1);
    chk("R2 chirp", chirp_en, 1);
    chk("R11 status", status, 2'b01);
    cable_in = 1'b0;
    cyc(2);
    chk("R8 not yet", pullup_en, 1);
    cyc(1);
    chk("R8 pullup off", pullup_en, 0);
    chk("R8 chirp off", chirp_en, 0);
  endtask

  task automatic t_locked();
    do_por();
    boot(1'b1, 8'h80);
    chk("R3 fw bit", fw_speed_dis, 1);
    chk("R3 lock", status[1], 1);
    attach();
    chk("R3 pullup", pullup_en, 1);
    chk("R3 chirp", chirp_en, 0);
    fw_write(1'b0);
    chk("R4 write ignored", fw_speed_dis, 1);
    detach();
    attach();
    chk("R4 reattach chirp", chirp_en, 0);
    ext_rst_n = 1'b0;
    cyc(6);
    chk("R7 ext reset drops pullup", pullup_en, 0);
    chk("R9 lock after ext reset", status[1], 1);
    ext_rst_n = 1'b1;
    cyc(6);
    chk("R9 chirp after ext reset", chirp_en, 0);
    boot(1'b1, 8'h00);
    chk("R10 late boot ignored lock", status[1], 1);
    chk("R10 late boot ignored fw", fw_speed_dis, 1);
    detach();
    chk("R9 lock after disconnect", status[1], 1);
    do_por();
    chk("R9 por clears lock", status[1], 0);
  endtask

  task automatic t_unlocked();
    do_por();
    boot(1'b1, 8'h7F);
    chk("R5 fw bit", fw_speed_dis, 0);
    chk("R5 no lock", status[1], 0);
    attach();
    chk("R5 chirp", chirp_en, 1);
    fw_write(1'b1);
    chk("R5 write seen", fw_speed_dis, 1);
    cyc(3);
    chk("R6 chirp held", chirp_en, 1);
    detach();
    attach();
    chk("R6 chirp after reattach", chirp_en, 0);
    chk("R11 status", status, 2'b00);
    fw_write(1'b0);
    chk("R5 write cleared", fw_speed_dis, 0);
    boot(1'b1, 8'h80);
    chk("R10 late boot no lock", status[1], 0);
    chk("R10 late boot no fw change", fw_speed_dis, 0);
    detach();
    attach();
    chk("R6 chirp back on", chirp_en, 1);
  endtask

  initial begin
    t_reset();
    t_no_cfg();
    t_locked();
    t_unlocked();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule